// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. Each cycle the surrounding sequencer may present the accumulator byte, a second operand byte, the current carry and auxiliary-carry flags, and a 4-bit operation code, qualified by `in_valid`. One clock later the block presents the result byte, new values for the carry (C), auxiliary carry (AC) and overflow (OV) flags, and a write enable for each flag. The sequencer writes a flag back only when its enable is high.

Flag updates depend on the operation. Additions and the borrow-including subtraction write all three flags. Increment, decrement and every bitwise, clear, plain-rotate and swap operation write none. The two rotates through carry write C only, and decimal adjust writes C only. Subtraction always consumes the incoming carry as a borrow, so software clears C first when it wants a plain difference.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to 0 on the next cycle.
- R2: Every output is registered. A request with `in_valid` high gives `res_valid` high one cycle later. A cycle with `in_valid` low gives `res_valid`, `cy_we`, `ac_we` and `ov_we` low one cycle later.
- R3: ADD (code 0) gives A+B, and ADDC (code 1) gives A+B+C, both modulo 256. C is set on a carry out of bit 7 and AC on a carry out of bit 3. OV is set when the carries into and out of bit 7 differ. All three flags are written. For example, 3Fh+D3h gives 12h with C=1, AC=1 and OV=0.
- R4: SUBB (code 2) gives A−B−C modulo 256. C is the borrow out of bit 7 and AC is the borrow out of bit 3. OV is set when the signed difference falls outside −128..127. All three flags are written.
- R5: INC (code 3) and DEC (code 4) give A+1 and A−1 with wrap-around and write no flag.
- R6: AND (5), OR (6) and XOR (7) combine A with B bitwise. CPL (8) inverts A and CLR (9) gives 0. None of them writes a flag.
- R7: RL (10) rotates A left with bit 7 entering bit 0. RR (11) rotates A right with bit 0 entering bit 7. Neither writes a flag.
- R8: RLC (12) and RRC (13) rotate the 9-bit ring formed by C and A. The bit that leaves A becomes the new C and the old C enters the vacated end. Only C is written.
- R9: SWAP (14) exchanges the two nibbles of A and writes no flag, so 72h gives 27h.
- R10: DA (15) first adds 06h when the low nibble is above 9 or AC=1. It then adds 60h when the high nibble is above 9, when C=1, or when the first step carried out. C is written and is set when C was 1 or either step carried out of bit 7, so DA never clears C. So 4Ch gives 52h.
- R11: When a flag is not written, its output carries the incoming value (`cy_in` and `ac_in`), and `ov_q` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| op_sel | input | 4 | Operation code |
| acc_in | input | DATA_W | Accumulator operand A |
| opnd_in | input | DATA_W | Second operand B |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| res_valid | output | 1 | Result present |
| res_q | output | DATA_W | Result byte |
| cy_q | output | 1 | Next carry value |
| ac_q | output | 1 | Next auxiliary carry value |
| ov_q | output | 1 | Next overflow value |
| cy_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Auxiliary carry write enable |
| ov_we | output | 1 | Overflow write enable |

## Verification
The bench targets the signed overflow boundaries. In 7Fh+73h both operands are positive and the sum turns negative, and in 80h−01h the difference crosses the signed limit. A design that took OV from the carry out alone would miss both. Borrow-chain cases such as 50h−20h−1 check that the incoming carry is subtracted and that AC reports the low-nibble borrow; a design that ignored C or inverted the borrow sense would show the wrong byte or flags. Decimal adjust is run with C already set on a value that needs no correction, and a design that recomputed C would clear it there. Increment of FFh and decrement of 00h are checked for wrap-around with every flag enable low, and the through-carry rotates are checked for a C write that leaves AC and OV alone.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_INC  = 4'd3,
    OP_DEC  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,  OP_CLR  = 4'd9,  OP_RL   = 4'd10, OP_RR   = 4'd11,
    OP_RLC  = 4'd12, OP_RRC  = 4'd13, OP_SWAP = 4'd14, OP_DA   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flag_we_t;

  function automatic flag_we_t flag_enables(input alu_op_e op);
    flag_we_t w;
    w = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: w = '{cy: 1'b1, ac: 1'b1, ov: 1'b1};
      OP_RLC, OP_RRC, OP_DA:    w = '{cy: 1'b1, ac: 1'b0, ov: 1'b0};
      default:                  w = '0;
    endcase
    return w;
  endfunction

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB) ||
           (op == OP_INC) || (op == OP_DEC) || (op == OP_DA);
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              acin,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  localparam int NIB = DATA_W / 2;
  localparam logic [NIB-1:0] DEC_MAX = NIB'(9);
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB;

  logic              is_sub;
  logic              c0;
  logic [DATA_W-1:0] bb;
  logic [NIB:0]      lo_sum;
  logic [DATA_W-1:0] hi7_sum;
  logic [DATA_W:0]   full_sum;
  logic              c7, c8, c4;
  logic              lo_adj, hi_adj;
  logic [DATA_W:0]   da1, da2;

  always_comb begin
    is_sub   = (op == OP_SUBB);
    bb       = is_sub ? ~b : b;
    c0       = (op == OP_ADD) ? 1'b0 : (is_sub ? ~cin : cin);
    lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, bb[NIB-1:0]} + (NIB+1)'(c0);
    hi7_sum  = {1'b0, a[DATA_W-2:0]} + {1'b0, bb[DATA_W-2:0]} + DATA_W'(c0);
    full_sum = {1'b0, a} + {1'b0, bb} + (DATA_W+1)'(c0);
    c4       = lo_sum[NIB];
    c7       = hi7_sum[DATA_W-1];
    c8       = full_sum[DATA_W];

    lo_adj   = (a[NIB-1:0] > DEC_MAX) || acin;
    da1      = {1'b0, a} + (lo_adj ? LO_FIX : '0);
    hi_adj   = (da1[DATA_W-1:NIB] > DEC_MAX) || cin || da1[DATA_W];
    da2      = {1'b0, da1[DATA_W-1:0]} + (hi_adj ? HI_FIX : '0);

    res = full_sum[DATA_W-1:0];
    cy  = is_sub ? ~c8 : c8;
    ac  = is_sub ? ~c4 : c4;
    ov  = c7 ^ c8;
    case (op)
      OP_INC: res = a + DATA_W'(1);
      OP_DEC: res = a - DATA_W'(1);
      OP_DA: begin
        res = da2[DATA_W-1:0];
        cy  = cin | da1[DATA_W] | da2[DATA_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cy
);
  localparam int NIB = DATA_W / 2;

  always_comb begin
    cy  = cin;
    res = a;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      OP_CLR:  res = '0;
      OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   res = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin
        res = {a[DATA_W-2:0], cin};
        cy  = a[DATA_W-1];
      end
      OP_RRC: begin
        res = {cin, a[DATA_W-1:1]};
        cy  = a[0];
      end
      OP_SWAP: res = {a[NIB-1:0], a[DATA_W-1:NIB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_q,
  output logic              cy_q,
  output logic              ac_q,
  output logic              ov_q,
  output logic              cy_we,
  output logic              ac_we,
  output logic              ov_we
);
  alu_op_e           op;
  flag_we_t          we_c;
  logic [DATA_W-1:0] ar_res, lg_res, res_c;
  logic              ar_cy, ar_ac, ar_ov, lg_cy;
  logic              cy_c, ac_c, ov_c;

  assign op = alu_op_e'(op_sel);

  acc_alu_arith #(.DATA_W(DATA_W)) arith_i (
    .op(op), .a(acc_in), .b(opnd_in), .cin(cy_in), .acin(ac_in),
    .res(ar_res), .cy(ar_cy), .ac(ar_ac), .ov(ar_ov)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) logic_i (
    .op(op), .a(acc_in), .b(opnd_in), .cin(cy_in),
    .res(lg_res), .cy(lg_cy)
  );

  always_comb begin
    we_c  = flag_enables(op);
    res_c = is_arith(op) ? ar_res : lg_res;
    if (!we_c.cy)           cy_c = cy_in;
    else if (is_arith(op))  cy_c = ar_cy;
    else                    cy_c = lg_cy;
    ac_c = we_c.ac ? ar_ac : ac_in;
    ov_c = we_c.ov ? ar_ov : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_q     <= '0;
      cy_q      <= 1'b0;
      ac_q      <= 1'b0;
      ov_q      <= 1'b0;
      cy_we     <= 1'b0;
      ac_we     <= 1'b0;
      ov_we     <= 1'b0;
    end else begin
      res_valid <= in_valid;
      cy_we     <= in_valid & we_c.cy;
      ac_we     <= in_valid & we_c.ac;
      ov_we     <= in_valid & we_c.ov;
      if (in_valid) begin
        res_q <= res_c;
        cy_q  <= cy_c;
        ac_q  <= ac_c;
        ov_q  <= ov_c;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic              cy_in,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_q,
  input logic              cy_q,
  input logic              cy_we,
  input logic              ac_we,
  input logic              ov_we
);
  localparam int NIB = DATA_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !res_valid && res_q == '0 && !cy_we); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> res_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !res_valid && !cy_we && !ac_we && !ov_we); // R2
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel == OP_ADD) |=> res_q == DATA_W'($past(acc_in) + $past(opnd_in)) && cy_we && ac_we && ov_we); // R3
  AST_SUB_ALL_FLAGS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel == OP_SUBB) |=> cy_we && ac_we && ov_we); // R4
  AST_STEP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst) (in_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=> !cy_we && !ac_we && !ov_we); // R5
  AST_BITWISE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel >= OP_AND && op_sel <= OP_RR) |=> !cy_we && !ac_we && !ov_we); // R6
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel == OP_RLC) |=> cy_q == $past(acc_in[DATA_W-1]) && cy_we && !ac_we && !ov_we); // R8
  AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel == OP_SWAP) |=> res_q == {$past(acc_in[NIB-1:0]), $past(acc_in[DATA_W-1:NIB])}); // R9
  AST_DA_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sel == OP_DA && cy_in) |=> cy_q && cy_we); // R10
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in),
  .res_valid(res_valid), .res_q(res_q), .cy_q(cy_q),
  .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] op_sel;
  logic [7:0] acc_in, opnd_in;
  logic       cy_in, ac_in;
  logic       res_valid;
  logic [7:0] res_q;
  logic       cy_q, ac_q, ov_q, cy_we, ac_we, ov_we;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  acc_alu #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
    .res_valid(res_valid), .res_q(res_q), .cy_q(cy_q), .ac_q(ac_q),
    .ov_q(ov_q), .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample at the next falling edge
  task automatic issue(input int op, input int a, input int b, input bit c, input bit h);
    in_valid = 1'b1;
    op_sel   = 4'(op);
    acc_in   = 8'(a);
    opnd_in  = 8'(b);
    cy_in    = c;
    ac_in    = h;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_all(input string req, input int res, input bit c, input bit h,
                            input bit v, input bit [2:0] we);
    chk(req, "valid", int'(res_valid), 1);
    chk(req, "result", int'(res_q), res);
    chk(req, "flags C/AC/OV", int'({cy_q, ac_q, ov_q}), int'({c, h, v}));
    chk(req, "enables C/AC/OV", int'({cy_we, ac_we, ov_we}), int'(we));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'hFF;
    cy_in = 1'b1; ac_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "outputs after reset",
        int'({res_valid, res_q, cy_q, ac_q, ov_q, cy_we, ac_we, ov_we}), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle;
    issue(0, 8'h11, 8'h22, 1'b0, 1'b0);
    chk("R2", "valid after request", int'(res_valid), 1);
    @(negedge clk);
    chk("R2", "idle valid/enables", int'({res_valid, cy_we, ac_we, ov_we}), 0);
  endtask

  task automatic t_add;
    issue(0, 8'h3F, 8'hD3, 1'b0, 1'b0); expect_all("R3", 8'h12, 1, 1, 0, 3'b111);
    issue(0, 8'h7F, 8'h73, 1'b1, 1'b0); expect_all("R3", 8'hF2, 0, 1, 1, 3'b111);
    issue(1, 8'h8F, 8'hD3, 1'b1, 1'b0); expect_all("R3", 8'h63, 1, 1, 1, 3'b111);
    for (int i = 0; i < 12; i++) begin
      int a, b, c, s, sa, sb, ss;
      a = (i * 37 + 5) % 256; b = (i * 53 + 200) % 256; c = i % 2;
      s = a + b + c;
      sa = (a > 127) ? a - 256 : a; sb = (b > 127) ? b - 256 : b; ss = sa + sb + c;
      issue(1, a, b, c[0], 1'b0);
      expect_all("R3", s % 256, s > 255, ((a % 16) + (b % 16) + c) > 15,
                 (ss > 127) || (ss < -128), 3'b111);
    end
  endtask

  task automatic t_sub;
    issue(2, 8'h50, 8'h20, 1'b1, 1'b0); expect_all("R4", 8'h2F, 0, 1, 0, 3'b111);
    issue(2, 8'h20, 8'h50, 1'b0, 1'b0); expect_all("R4", 8'hD0, 1, 0, 0, 3'b111);
    issue(2, 8'h80, 8'h01, 1'b0, 1'b0); expect_all("R4", 8'h7F, 0, 1, 1, 3'b111);
    for (int i = 0; i < 12; i++) begin
      int a, b, c, d, sa, sb, sd;
      a = (i * 71 + 9) % 256; b = (i * 29 + 90) % 256; c = (i / 2) % 2;
      d = a - b - c;
      sa = (a > 127) ? a - 256 : a; sb = (b > 127) ? b - 256 : b; sd = sa - sb - c;
      issue(2, a, b, c[0], 1'b1);
      expect_all("R4", (d + 256) % 256, d < 0, ((a % 16) - (b % 16) - c) < 0,
                 (sd > 127) || (sd < -128), 3'b111);
    end
  endtask

  task automatic t_step;
    issue(3, 8'hFF, 8'h00, 1'b1, 1'b0); expect_all("R5", 8'h00, 1, 0, 0, 3'b000);
    issue(4, 8'h00, 8'h00, 1'b0, 1'b1); expect_all("R5", 8'hFF, 0, 1, 0, 3'b000);
  endtask

  task automatic t_bitwise;
    issue(5, 8'h0F, 8'hAC, 1'b1, 1'b1); expect_all("R6", 8'h0C, 1, 1, 0, 3'b000);
    issue(6, 8'h0F, 8'hAC, 1'b0, 1'b0); expect_all("R6", 8'hAF, 0, 0, 0, 3'b000);
    issue(7, 8'h0F, 8'hAC, 1'b0, 1'b1); expect_all("R6", 8'hA3, 0, 1, 0, 3'b000);
    issue(8, 8'hAC, 8'h00, 1'b1, 1'b0); expect_all("R6", 8'h53, 1, 0, 0, 3'b000);
    issue(9, 8'hAC, 8'h00, 1'b0, 1'b0); expect_all("R6", 8'h00, 0, 0, 0, 3'b000);
  endtask

  task automatic t_rotate;
    issue(10, 8'hF0, 8'h00, 1'b0, 1'b0); expect_all("R7", 8'hE1, 0, 0, 0, 3'b000);
    issue(11, 8'hF0, 8'h00, 1'b1, 1'b0); expect_all("R7", 8'h78, 1, 0, 0, 3'b000);
    issue(12, 8'h3C, 8'h00, 1'b1, 1'b1); expect_all("R8", 8'h79, 0, 1, 0, 3'b100);
    issue(13, 8'hBD, 8'h00, 1'b0, 1'b0); expect_all("R8", 8'h5E, 1, 0, 0, 3'b100);
  endtask

  task automatic t_swap;
    issue(14, 8'h72, 8'h00, 1'b0, 1'b0); expect_all("R9", 8'h27, 0, 0, 0, 3'b000);
  endtask

  task automatic t_da;
    issue(15, 8'h4C, 8'h00, 1'b0, 1'b0); expect_all("R10", 8'h52, 0, 0, 0, 3'b100);
    issue(15, 8'h9A, 8'h00, 1'b0, 1'b0); expect_all("R10", 8'h00, 1, 0, 0, 3'b100);
    issue(15, 8'h23, 8'h00, 1'b1, 1'b0); expect_all("R10", 8'h83, 1, 0, 0, 3'b100);
    issue(15, 8'h41, 8'h00, 1'b0, 1'b1); expect_all("R10", 8'h47, 0, 1, 0, 3'b100);
  endtask

  task automatic t_passthru;
    // R11: unwritten C and AC echo the inputs, OV reads 0
    issue(6, 8'h01, 8'h02, 1'b1, 1'b1); expect_all("R11", 8'h03, 1, 1, 0, 3'b000);
    issue(12, 8'h80, 8'h00, 1'b0, 1'b1); expect_all("R11", 8'h00, 1, 1, 0, 3'b100);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_idle;
    t_add;
    t_sub;
    t_step;
    t_bitwise;
    t_rotate;
    t_swap;
    t_da;
    t_passthru;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule